// File: doc/BRIEF.md
# Configuration Stream Sync Aligner

This block sits in the path that carries a configuration image from memory towards a configuration port. The image arrives as a byte stream with an unknown header ahead of the payload. The block watches the stream for a fixed four-byte marker and discards every byte that comes before it. From the marker on, it groups the bytes into 32-bit words and hands them on with the byte order inside each word reversed, so that the first byte of each group lands in the most significant byte.

Each stream is closed by a `last` flag on its final byte. A trailing group of fewer than four bytes still yields one word, with zero bytes filling the unused positions. If a stream ends without the marker, no word is produced and an error flag is raised. A count of the words produced for the current stream is available at all times. Backpressure on the word side stalls the byte side, and no byte is lost. Parsing of the configuration packets that follow the marker is left to the consumer.

Top module: `bitstream_aligner`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, word_count is 0 and nosync_err is 0.
- R2: The marker is the bytes 0xAA, 0x99, 0x55, 0x66 in order of arrival. Bytes before its first occurrence produce no output. The first word of a stream that contains the marker is 0xAA995566.
- R3: A marker that overlaps a partial marker in the header is found. Examples are AA AA 99 55 66 and AA 99 55 AA 99 55 66.
- R4: After the first marker, further copies of the marker are passed on as ordinary data.
- R5: Each output word holds four consecutive kept bytes. The earliest byte is in bits 31:24 and the latest is in bits 7:0.
- R6: A stream that keeps N bytes produces ceil(N/4) words. In a trailing partial word, the byte positions that have no data are zero.
- R7: out_last is 1 on the word that contains the final kept byte of a stream and 0 on every other word.
- R8: A stream whose last byte is accepted without a marker having been found produces no word. nosync_err becomes 1 in the cycle after that byte is accepted. It stays 1 until the first byte of the next stream is accepted.
- R9: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_data and out_last hold their values. Every input byte is still accounted for in the output.
- R10: word_count equals the number of words produced for the current stream. It updates in the cycle after the byte that completes a word is accepted. It returns to 0 when the first byte of the next stream is accepted.
- R11: The search starts over for each stream. Bytes from an earlier stream never form part of a marker together with bytes from a later stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can accept a byte this cycle |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the final byte of the stream |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word this cycle |
| out_data | output | 32 | Output word, earliest kept byte in bits 31:24 |
| out_last | output | 1 | Word holds the final kept byte of the stream |
| word_count | output | CNT_W | Words produced for the current stream |
| nosync_err | output | 1 | Previous stream ended without a marker |

## Verification
The bench sweeps every header length from zero to six, using headers that end in each partial prefix of the marker. It pairs each with payload lengths from zero to nine bytes, so every trailing-word fill and every overlap case is covered. A design that restarted its search by discarding the window on a failed compare would miss the overlapping markers and report no-sync instead. A design that kept searching after the first match would drop or misalign a payload that carries a second marker. A design that padded from the wrong end, or counted kept bytes with floor instead of ceiling, would show a wrong last word or a missing last word.

Three output-ready patterns check that a stall holds the word and blocks input without losing bytes. Back-to-back streams check two further behaviours. A marker split across a stream boundary must not be found. The error flag and the count must clear only when the next stream's first byte is accepted.

// File: rtl/bsa_pkg.sv
// Package: shared constants and types for the sync aligner.
// Assumes a byte-wide input and a marker exactly one output word long.
package bsa_pkg;
    localparam int          BYTE_W     = 8;
    localparam int          WORD_BYTES = 4;
    localparam int          WORD_W     = BYTE_W * WORD_BYTES;
    // Marker with the earliest arriving byte in the top byte lane.
    localparam logic [31:0] SYNC_WORD  = 32'hAA99_5566;

    typedef enum logic {
        ST_HUNT = 1'b0,   // looking for the marker
        ST_PASS = 1'b1    // marker found, packing payload
    } bsa_state_e;
endpackage

// File: rtl/bsa_sync_window.sv
// Module: sliding window over the most recent bytes of the stream.
// Compares the previous NBYTES-1 bytes plus the byte now offered
// against the marker every cycle, so a partial match that overlaps
// the true marker is never skipped. Assumes the caller shifts only
// on accepted bytes and flushes at stream ends and on a match.
module bsa_sync_window #(
    parameter int                  NBYTES  = bsa_pkg::WORD_BYTES,
    parameter logic [8*NBYTES-1:0] PATTERN = bsa_pkg::SYNC_WORD
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shift_en,
    input  logic       flush,
    input  logic [7:0] byte_in,
    output logic       match
);
    localparam int TAPS = NBYTES - 1;

    logic [7:0]          tap_q [TAPS];
    logic [8*NBYTES-1:0] cand;

    // Purpose: place older bytes above the newest one in the candidate.
    assign cand[7:0] = byte_in;
    generate
        for (genvar t = 0; t < TAPS; t++) begin : g_cand
            assign cand[8*(t+1) +: 8] = tap_q[t];
        end
    endgenerate

    // Purpose: report a full marker including the byte on the input.
    assign match = (cand == PATTERN);

    // Purpose: shift accepted bytes into the window, or clear it.
    always_ff @(posedge clk) begin
        if (!rst_n || (shift_en && flush)) begin
            for (int t = 0; t < TAPS; t++) tap_q[t] <= '0;
        end else if (shift_en) begin
            tap_q[0] <= byte_in;
            for (int t = 1; t < TAPS; t++) tap_q[t] <= tap_q[t-1];
        end
    end
endmodule

// File: rtl/bsa_word_packer.sv
// Module: groups kept bytes into words and holds one output word.
// The earliest byte of a group goes to the top byte lane. A group
// closed early by the stream end is zero-filled. Counts words
// produced per stream. Assumes the caller offers a byte or the
// marker only when the output register is free or being drained.
module bsa_word_packer #(
    parameter int                  WORD_BYTES = bsa_pkg::WORD_BYTES,
    parameter logic [8*WORD_BYTES-1:0] SYNC   = bsa_pkg::SYNC_WORD,
    parameter int                  CNT_W      = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take_byte,
    input  logic                    take_sync,
    input  logic [7:0]              byte_in,
    input  logic                    last_in,
    input  logic                    new_stream,
    input  logic                    out_ready,
    output logic                    out_valid,
    output logic [8*WORD_BYTES-1:0] out_data,
    output logic                    out_last,
    output logic [CNT_W-1:0]        word_cnt
);
    localparam int WORD_W = 8 * WORD_BYTES;
    localparam int IDX_W  = $clog2(WORD_BYTES);
    localparam int ACC_N  = WORD_BYTES - 1;

    logic [7:0]       acc_q [ACC_N];
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       merged [WORD_BYTES];
    logic [WORD_W-1:0] packed_word;
    logic             word_full;
    logic             close_grp;
    logic             emit;

    // Purpose: overlay the offered byte on the bytes gathered so far.
    generate
        for (genvar j = 0; j < WORD_BYTES; j++) begin : g_lane
            if (j < ACC_N) begin : g_held
                assign merged[j] = (idx_q == IDX_W'(j)) ? byte_in : acc_q[j];
            end else begin : g_tail
                assign merged[j] = (idx_q == IDX_W'(j)) ? byte_in : 8'h00;
            end
            assign packed_word[WORD_W-1-8*j -: 8] = merged[j];
        end
    endgenerate

    // Purpose: decide when a group closes and a word is produced.
    assign word_full = (idx_q == IDX_W'(WORD_BYTES - 1));
    assign close_grp = take_byte && (word_full || last_in);
    assign emit      = take_sync || close_grp;

    // Purpose: gather bytes of the open group, clear on close.
    always_ff @(posedge clk) begin
        if (!rst_n || take_sync || close_grp) begin
            idx_q <= '0;
            for (int j = 0; j < ACC_N; j++) acc_q[j] <= '0;
        end else if (take_byte) begin
            idx_q <= idx_q + 1'b1;
            for (int j = 0; j < ACC_N; j++)
                if (idx_q == IDX_W'(j)) acc_q[j] <= byte_in;
        end
    end

    // Purpose: one-word output register with ready/valid handover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else if (emit) begin
            out_valid <= 1'b1;
            out_data  <= take_sync ? SYNC : packed_word;
            out_last  <= last_in;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Purpose: count words produced in the current stream.
    always_ff @(posedge clk) begin
        if (!rst_n)          word_cnt <= '0;
        else if (new_stream) word_cnt <= emit ? CNT_W'(1) : '0;
        else if (emit)       word_cnt <= word_cnt + 1'b1;
    end

    // R9: nothing is loaded while a word waits for the consumer.
    p_stall_blocks_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !(take_byte || take_sync));

    // R9: a stalled word stays put.
    p_stall_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R10: the count steps by one or restarts.
    p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (word_cnt == $past(word_cnt) || word_cnt == $past(word_cnt) + 1'b1
                  || word_cnt <= CNT_W'(1)));
endmodule

// File: rtl/bitstream_aligner.sv
// Module: top of the sync aligner. Hunts for the marker in each
// byte stream, then packs the rest into byte-reversed words.
// Raises nosync_err when a stream ends without a marker. Assumes
// every stream is closed by in_last on its final byte.
module bitstream_aligner #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [31:0]      out_data,
    output logic             out_last,
    output logic [CNT_W-1:0] word_count,
    output logic             nosync_err
);
    import bsa_pkg::*;

    bsa_state_e state_q;
    logic       at_start_q;
    logic       accept;
    logic       match;
    logic       hunting;
    logic       take_sync;
    logic       take_byte;

    // Purpose: accept a byte whenever the output register can take a word.
    assign in_ready  = !out_valid || out_ready;
    assign accept    = in_valid && in_ready;
    assign hunting   = (state_q == ST_HUNT);
    assign take_sync = accept && hunting && match;
    assign take_byte = accept && !hunting;

    bsa_sync_window #(
        .NBYTES  (WORD_BYTES),
        .PATTERN (SYNC_WORD)
    ) win_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (accept && hunting),
        .flush    (in_last || match),
        .byte_in  (in_data),
        .match    (match)
    );

    bsa_word_packer #(
        .WORD_BYTES (WORD_BYTES),
        .SYNC       (SYNC_WORD),
        .CNT_W      (CNT_W)
    ) pack_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_byte  (take_byte),
        .take_sync  (take_sync),
        .byte_in    (in_data),
        .last_in    (in_last),
        .new_stream (accept && at_start_q),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_last   (out_last),
        .word_cnt   (word_count)
    );

    // Purpose: hunt until the marker, pass until the stream ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                                state_q <= ST_HUNT;
        else if (take_sync && !in_last)            state_q <= ST_PASS;
        else if (take_byte && in_last)             state_q <= ST_HUNT;
    end

    // Purpose: remember whether the next accepted byte opens a stream.
    always_ff @(posedge clk) begin
        if (!rst_n)      at_start_q <= 1'b1;
        else if (accept) at_start_q <= in_last;
    end

    // Purpose: flag a stream that ended with no marker, clear on next one.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  nosync_err <= 1'b0;
        else if (accept && hunting && in_last && !match) nosync_err <= 1'b1;
        else if (accept && at_start_q)               nosync_err <= 1'b0;
    end

    // R2: a found marker becomes the next output word.
    p_sync_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_sync |=> (out_valid && out_data == SYNC_WORD));

    // R7: the final kept byte yields a word flagged last.
    p_last_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_last && (!hunting || match)) |=> (out_valid && out_last));

    // R8: a no-sync stream has produced no word.
    p_err_no_words_r8: assert property (@(posedge clk) disable iff (!rst_n)
        nosync_err |-> (word_count == '0));
endmodule

// File: tb/bitstream_aligner_tb_top.sv
`timescale 1ns/1ps
module bitstream_aligner_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        out_last;
    logic [15:0] word_count;
    logic        nosync_err;

    always #4 clk = ~clk;

    bitstream_aligner #(.CNT_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .word_count(word_count), .nosync_err(nosync_err)
    );

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [7:0]  stim [64];
    int          slen;
    logic [31:0] expw [16];
    int          exp_n;
    bit          exp_err;
    logic [31:0] gotw [32];
    bit          gotl [32];
    int          got_n;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Reference: first marker position, ceil word count, zero fill, top-lane first.
    function automatic void model();
        int pos = -1;
        for (int i = 0; i + 3 < slen; i++)
            if (pos < 0 && stim[i] == 8'hAA && stim[i+1] == 8'h99 &&
                stim[i+2] == 8'h55 && stim[i+3] == 8'h66) pos = i;
        if (pos < 0) begin
            exp_n = 0; exp_err = 1'b1;
        end else begin
            exp_err = 1'b0;
            exp_n = (slen - pos + 3) / 4;
            for (int w = 0; w < exp_n; w++)
                for (int j = 0; j < 4; j++) begin
                    int k = pos + 4*w + j;
                    expw[w][31-8*j -: 8] = (k < slen) ? stim[k] : 8'h00;
                end
        end
    endfunction

    function automatic bit ready_pat(input int mode, input int cyc);
        case (mode)
            0: return 1'b1;
            1: return (cyc % 2) == 0;
            default: return (cyc % 3) == 2;
        endcase
    endfunction

    task automatic run_stream(input int mode, input string tag);
        int sent = 0;
        int cyc = 0;
        int idle = 0;
        bit stalled = 1'b0;
        bit first_chk = 1'b0;
        logic [31:0] stall_w = '0;
        bit stall_l = 1'b0;
        got_n = 0;
        model();
        while (sent < slen || idle < 8) begin
            @(negedge clk);
            out_ready = ready_pat(mode, cyc);
            cyc++;
            if (sent < slen) begin
                in_valid = 1'b1; in_data = stim[sent]; in_last = (sent == slen - 1);
            end else begin
                in_valid = 1'b0; in_data = '0; in_last = 1'b0;
            end
            #1;
            if (first_chk) begin
                chk(nosync_err == 1'b0, {"R8 flag clears on new stream ", tag}, 32'(nosync_err), 0);
                chk(word_count == 16'd0, {"R10 count clears on new stream ", tag}, 32'(word_count), 0);
                first_chk = 1'b0;
            end
            if (stalled)
                chk(out_valid && out_data == stall_w && out_last == stall_l,
                    {"R9 stalled word held ", tag}, out_data, stall_w);
            if (out_valid && !out_ready)
                chk(!in_ready, {"R9 input blocked on stall ", tag}, 32'(in_ready), 0);
            stalled = out_valid && !out_ready;
            stall_w = out_data;
            stall_l = out_last;
            if (out_valid && out_ready) begin
                if (got_n < 32) begin gotw[got_n] = out_data; gotl[got_n] = out_last; end
                got_n++;
            end
            if (in_valid && in_ready) begin
                if (sent == 0 && slen > 1) first_chk = 1'b1;
                sent++;
            end
            if (sent >= slen) idle = out_valid ? 0 : idle + 1;
        end
        in_valid = 1'b0; in_last = 1'b0;
        chk(got_n == exp_n, {"R6 word total ", tag}, 32'(got_n), 32'(exp_n));
        for (int w = 0; w < exp_n && w < got_n; w++) begin
            chk(gotw[w] == expw[w], {(w == 0) ? "R2 first word " : "R5 word order ", tag},
                gotw[w], expw[w]);
            chk(gotl[w] == (w == exp_n - 1), {"R7 last flag ", tag}, 32'(gotl[w]),
                32'(w == exp_n - 1));
        end
        chk(word_count == 16'(exp_n), {"R10 word_count ", tag}, 32'(word_count), 32'(exp_n));
        chk(nosync_err == exp_err, {"R8 nosync_err ", tag}, 32'(nosync_err), 32'(exp_err));
    endtask

    // Header bytes ending in each partial prefix of the marker (R3).
    function automatic logic [7:0] hdr_byte(input int k);
        case (k)
            0: return 8'h55; 1: return 8'hAA; 2: return 8'h99;
            3: return 8'h55; 4: return 8'hAA; default: return 8'hAA;
        endcase
    endfunction

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles == 150000) begin
                bad++; total++;
                $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 1);
        chk(word_count == 16'd0, "R1 word_count after reset", 32'(word_count), 0);
        chk(nosync_err == 1'b0, "R1 nosync_err after reset", 32'(nosync_err), 0);

        // Sweep: header 0..6, payload 0..9, three ready patterns (R2/R3/R5/R6/R7/R9).
        for (int h = 0; h <= 6; h++)
            for (int p = 0; p <= 9; p++)
                for (int m = 0; m < 3; m++) begin
                    slen = 0;
                    for (int k = 0; k < h; k++) begin stim[slen] = hdr_byte(k); slen++; end
                    stim[slen] = 8'hAA; stim[slen+1] = 8'h99;
                    stim[slen+2] = 8'h55; stim[slen+3] = 8'h66; slen += 4;
                    for (int k = 0; k < p; k++) begin stim[slen] = 8'(k*59 + 7); slen++; end
                    run_stream(m, $sformatf("R3 sweep h=%0d p=%0d m=%0d", h, p, m));
                end

        // R4: a second marker in the payload is data.
        slen = 11;
        stim[0] = 8'h12; stim[1] = 8'h34;
        stim[2] = 8'hAA; stim[3] = 8'h99; stim[4] = 8'h55; stim[5] = 8'h66;
        stim[6] = 8'hAA; stim[7] = 8'h99; stim[8] = 8'h55; stim[9] = 8'h66;
        stim[10] = 8'h11;
        for (int m = 0; m < 3; m++) run_stream(m, $sformatf("R4 repeat marker m=%0d", m));

        // R8: streams with no marker, lengths 1..6, each followed by a good stream.
        for (int n = 1; n <= 6; n++) begin
            slen = n;
            for (int k = 0; k < n; k++) stim[k] = hdr_byte(k + 1);
            run_stream(1, $sformatf("R8 no marker len=%0d", n));
            slen = 5;
            stim[0] = 8'hAA; stim[1] = 8'h99; stim[2] = 8'h55; stim[3] = 8'h66; stim[4] = 8'h3C;
            run_stream(0, $sformatf("R8 recovery after len=%0d", n));
        end

        // R11: marker split across two streams must not be found.
        slen = 3; stim[0] = 8'hAA; stim[1] = 8'h99; stim[2] = 8'h55;
        run_stream(0, "R11 first half");
        slen = 3; stim[0] = 8'h66; stim[1] = 8'h01; stim[2] = 8'h02;
        run_stream(0, "R11 second half");
        slen = 2; stim[0] = 8'hAA; stim[1] = 8'h99;
        run_stream(2, "R11 short head");
        slen = 6; stim[0] = 8'h55; stim[1] = 8'h66; stim[2] = 8'h00;
        stim[3] = 8'h01; stim[4] = 8'h02; stim[5] = 8'h03;
        run_stream(2, "R11 short tail");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule